// File: doc/BRIEF.md
# Programming Mode Entry Sequencer

This block decides whether a microcontroller may hand its embedded memory to an external programmer. It watches the chip-level reset pin, an auxiliary reset pin, a program-reset pin and a two-wire test port (test clock and test data). It raises the parallel host interface enable only after these have moved through a fixed order:

- the auxiliary reset is pulsed while the main reset is held low;
- the program-reset pin opens a key window;
- an eight-bit serial key plus one spare bit is shifted in;
- a minimum number of further test clocks has passed.

A ready/busy output and a power-on status output tell the programmer how far the sequence has reached. When the read-protect byte is set, ready/busy is held low for an extra, parameterized period before the mode is granted. Letting the main reset go high at any time sends the device back to user mode.

All pins are taken as already synchronous to the system clock. The test clock is oversampled, so one low-to-high change between two system clock samples counts as one test clock edge. The reset pulse width and the protection busy time are counted in system clocks.

Top module: `prog_entry_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `rdy_busy`, `por_ok` and `host_mode` are 0 until an entry sequence completes.
- R2: With `main_rst_n` low, `aux_rst_n` must be seen low on at least T_RST_CYC (default 4) consecutive clock edges and then high. A shorter low pulse leaves the block idle, and a following key has no effect.
- R3: After a valid reset pulse, test clock edges are ignored until `prg_rst` is seen low, which opens the key window.
- R4: In the key window the key 8'hD3 is sampled from `tdi`, most significant bit first, on the first eight test clock rising edges. The ninth edge is a spare bit whose value is ignored. `rdy_busy` and `por_ok` become 1 one clock after that ninth edge, and remain 0 before it.
- R5: A key bit that differs from the key returns the block to idle, so `por_ok` stays 0. A new key is accepted only after a fresh reset pulse, even if the key window is reopened.
- R6: `host_mode` becomes 1 one clock after the 24th test clock rising edge that follows the key, and is still 0 after the 23rd.
- R7: If `rdprot` is 1 at the 24th edge, `rdy_busy` goes 0 for PROT_CYC (default 6) clocks while `por_ok` stays 1. Then `rdy_busy` and `host_mode` both become 1.
- R8: If `rdprot` is 0 at the 24th edge, `rdy_busy` stays 1 and `host_mode` becomes 1 at once.
- R9: `main_rst_n` seen high in any state returns the block to idle. All three outputs are 0 one clock later, and they stay 0 after `main_rst_n` goes low again without a new sequence.
- R10: A test clock edge is a 0 sample followed by a 1 sample. Holding `tck` high across several clocks counts as a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously inside |
| main_rst_n | input | 1 | Chip main reset pin, low to allow entry |
| aux_rst_n | input | 1 | Auxiliary reset pin, pulsed low to arm entry |
| prg_rst | input | 1 | Program-reset pin, low opens the key window |
| tck | input | 1 | Test clock, oversampled |
| tdi | input | 1 | Test data, sampled on test clock rising edges |
| rdprot | input | 1 | Read-protect byte is set |
| rdy_busy | output | 1 | Ready (1) / busy (0) indication |
| por_ok | output | 1 | Power-on status, high once the key is accepted |
| host_mode | output | 1 | Enables the parallel host programming interface |

## Verification
The outputs are decoded straight from the state register. Each result therefore appears one clock after the system clock edge that first sees the deciding input (a reset-pin level, a test clock rising edge, or the last protection count). The bench changes inputs on falling clock edges and reads outputs on later falling edges. A test clock pulse task returns two falling edges after it raises `tck`, so the edge has been sampled and the state update is visible when the checks run. The protection phase is measured by counting the falling-edge samples on which `rdy_busy` is low. That count is PROT_CYC-1, because the first low clock lies inside the pulse task.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PULSE = 3'd1,
    ST_ARMED = 3'd2,
    ST_KEY   = 3'd3,
    ST_POST  = 3'd4,
    ST_PROT  = 3'd5,
    ST_HOST  = 3'd6
  } pe_state_t;
endpackage

// File: rtl/pe_rise.sv
// Rising-edge detector for an oversampled slow strobe.
module pe_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;

  // R10: a detected edge is never followed by another without a low sample
  a_r10_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pe_counter.sv
// Shared up-counter with synchronous clear and saturation.
module pe_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)                 cnt_d = '0;
    else if (inc && ~&cnt)   cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R2: a long reset pulse must not wrap the width count back to small values
  a_r2_cnt_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt && !clr) |=> &cnt);
endmodule

// File: rtl/prog_entry_seq.sv
module prog_entry_seq
  import pe_pkg::*;
#(
  parameter int          T_RST_CYC = 4,
  parameter int          KEY_W     = 8,
  parameter logic [KEY_W-1:0] KEY_VAL = 8'hD3,
  parameter int          POST_CLKS = 24,
  parameter int          PROT_CYC  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_rst_n,
  input  logic aux_rst_n,
  input  logic prg_rst,
  input  logic tck,
  input  logic tdi,
  input  logic rdprot,
  output logic rdy_busy,
  output logic por_ok,
  output logic host_mode
);
  localparam int M1   = (T_RST_CYC > POST_CLKS) ? T_RST_CYC : POST_CLKS;
  localparam int M2   = (PROT_CYC > KEY_W + 1) ? PROT_CYC : KEY_W + 1;
  localparam int MAXV = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXV + 1) + 1;

  // reset: asynchronous assert, synchronous release
  logic rst_q1, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_s  <= rst_q1;
    end
  end

  pe_state_t    st, st_d;
  logic         cnt_clr, cnt_inc, tck_rise;
  logic [CW-1:0] cnt;
  logic [KEY_W-1:0] key_sh;

  pe_rise u_rise (
    .clk  (clk),
    .rst_n(rst_s),
    .sig  (tck),
    .rise (tck_rise)
  );

  pe_counter #(.W(CW)) u_cnt (
    .clk  (clk),
    .rst_n(rst_s),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .cnt  (cnt)
  );

  // expected key bit sits at the top after shifting by the bit index
  assign key_sh = KEY_VAL << cnt;

  always_comb begin
    st_d    = st;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (st != ST_IDLE && main_rst_n) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: if (!main_rst_n && !aux_rst_n) begin
          st_d    = ST_PULSE;
          cnt_clr = 1'b1;
        end
        ST_PULSE: begin
          if (aux_rst_n) st_d = (cnt >= CW'(T_RST_CYC - 1)) ? ST_ARMED : ST_IDLE;
          else           cnt_inc = 1'b1;
        end
        ST_ARMED: if (!prg_rst) begin
          st_d    = ST_KEY;
          cnt_clr = 1'b1;
        end
        ST_KEY: if (tck_rise) begin
          if (cnt == CW'(KEY_W)) begin
            st_d    = ST_POST;
            cnt_clr = 1'b1;
          end else if (tdi != key_sh[KEY_W-1]) begin
            st_d = ST_IDLE;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        ST_POST: if (tck_rise) begin
          if (cnt == CW'(POST_CLKS - 1)) begin
            st_d    = rdprot ? ST_PROT : ST_HOST;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        ST_PROT: begin
          if (cnt == CW'(PROT_CYC - 1)) st_d = ST_HOST;
          else                          cnt_inc = 1'b1;
        end
        ST_HOST: st_d = ST_HOST;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) st <= ST_IDLE;
    else        st <= st_d;
  end

  assign rdy_busy  = (st == ST_POST) || (st == ST_HOST);
  assign por_ok    = (st == ST_POST) || (st == ST_PROT) || (st == ST_HOST);
  assign host_mode = (st == ST_HOST);

  // R9: main reset high forces user mode on the next clock
  a_r9_main_release: assert property (@(posedge clk) disable iff (!rst_s)
    main_rst_n |=> (!por_ok && !host_mode && !rdy_busy));

  // R4: status rises only on leaving the key phase
  a_r4_por_after_key: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(por_ok) |-> ($past(st) == ST_KEY));

  // R6: host mode is granted only from the post-key or protection phase
  a_r6_host_entry: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(host_mode) |-> ($past(st) == ST_POST || $past(st) == ST_PROT));

  // R7: ready/busy falls only into the protection phase or on exit to idle
  a_r7_busy_drop: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(rdy_busy) |-> (st == ST_PROT || st == ST_IDLE));

  // R2: a too-short auxiliary pulse never arms the key window
  a_r2_short_pulse: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_PULSE && aux_rst_n && !main_rst_n && cnt < CW'(T_RST_CYC - 1))
      |=> (st == ST_IDLE));

  // R5: the key bit index never runs past the spare bit
  a_r5_key_index: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_KEY) |-> (cnt <= CW'(KEY_W)));
endmodule

// File: tb/prog_entry_seq_tb_top.sv
`timescale 1ns/1ps
module prog_entry_seq_tb_top;
  localparam int T_RST = 4;
  localparam int POSTN = 24;
  localparam int PROTN = 6;

  logic clk, rst_n, main_rst_n, aux_rst_n, prg_rst, tck, tdi, rdprot;
  logic rdy_busy, por_ok, host_mode;
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  prog_entry_seq #(.T_RST_CYC(T_RST), .POST_CLKS(POSTN), .PROT_CYC(PROTN)) dut_i (
    .clk(clk), .rst_n(rst_n), .main_rst_n(main_rst_n), .aux_rst_n(aux_rst_n),
    .prg_rst(prg_rst), .tck(tck), .tdi(tdi), .rdprot(rdprot),
    .rdy_busy(rdy_busy), .por_ok(por_ok), .host_mode(host_mode)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {key[7:0], spare bit, rdprot, key accepted}
  localparam logic [10:0] VEC [6] = '{
    {8'hD3, 1'b0, 1'b0, 1'b1},
    {8'hD3, 1'b1, 1'b1, 1'b1},
    {8'hD2, 1'b0, 1'b0, 1'b0},
    {8'h53, 1'b1, 1'b0, 1'b0},
    {8'hD7, 1'b0, 1'b1, 1'b0},
    {8'hD3, 1'b1, 1'b0, 1'b1}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tck_pulse(input logic b, input int hi);
    tdi = b;
    tck = 1'b1;
    repeat (hi) tick();
    tck = 1'b0;
    tick();
  endtask

  task automatic go_idle();
    main_rst_n = 1'b1; prg_rst = 1'b1; aux_rst_n = 1'b1; tck = 1'b0; tdi = 1'b0;
    tick(); tick();
    main_rst_n = 1'b0;
    tick();
  endtask

  task automatic reset_pulse(input int n);
    aux_rst_n = 1'b0;
    repeat (n) tick();
    aux_rst_n = 1'b1;
    tick();
  endtask

  task automatic open_window();
    prg_rst = 1'b0;
    tick();
  endtask

  task automatic send_key(input logic [7:0] k, input logic spare);
    for (int i = 7; i >= 0; i--) tck_pulse(k[i], 1);
    tck_pulse(spare, 1);
  endtask

  task automatic post_clocks(input int n);
    for (int i = 0; i < n; i++) tck_pulse(1'b0, 1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; main_rst_n = 1'b1; aux_rst_n = 1'b1; prg_rst = 1'b1;
    tck = 1'b0; tdi = 1'b0; rdprot = 1'b0;
    tick(); tick();
    chk(por_ok, 1'b0, "R1 por in reset");
    chk(rdy_busy, 1'b0, "R1 rdy in reset");
    rst_n = 1'b1;
    repeat (3) tick();
    chk(host_mode, 1'b0, "R1 host after reset");
    chk(rdy_busy, 1'b0, "R1 rdy after reset");

    // table-driven entries (R4, R5, R6, R7, R8)
    foreach (VEC[v]) begin
      go_idle();
      rdprot = VEC[v][1];
      reset_pulse(T_RST);
      open_window();
      for (int i = 7; i >= 0; i--) tck_pulse(VEC[v][3+i], 1);
      chk(por_ok, 1'b0, "R4 no status before spare bit");
      tck_pulse(VEC[v][2], 1);
      chk(por_ok, VEC[v][0], "R4/R5 status after key");
      chk(rdy_busy, VEC[v][0], "R4/R5 ready after key");
      if (VEC[v][0]) begin
        post_clocks(POSTN - 1);
        chk(host_mode, 1'b0, "R6 no host after 23 clocks");
        tck_pulse(1'b0, 1);
        if (VEC[v][1]) begin
          int lc = 0;
          chk(rdy_busy, 1'b0, "R7 busy during protection");
          chk(por_ok, 1'b1, "R7 status held");
          while (!rdy_busy && lc < 50) begin
            lc++;
            tick();
          end
          checks++;
          if (lc != PROTN - 1) begin
            errors++;
            $display("FAIL R7 busy samples actual=%0d expected=%0d", lc, PROTN - 1);
          end
          chk(host_mode, 1'b1, "R7 host after protection");
        end else begin
          chk(rdy_busy, 1'b1, "R8 ready stays high");
          chk(host_mode, 1'b1, "R8 host granted");
        end
      end
    end

    // R2: short pulse does not arm
    go_idle();
    rdprot = 1'b0;
    reset_pulse(T_RST - 1);
    open_window();
    send_key(8'hD3, 1'b0);
    chk(por_ok, 1'b0, "R2 short pulse rejected");

    // R3: key before window ignored, then accepted
    go_idle();
    reset_pulse(T_RST);
    send_key(8'hD3, 1'b0);
    chk(por_ok, 1'b0, "R3 edges before window ignored");
    open_window();
    send_key(8'hD3, 1'b0);
    chk(por_ok, 1'b1, "R3 key accepted after window");

    // R9: release during post-key phase
    main_rst_n = 1'b1;
    tick();
    chk(rdy_busy, 1'b0, "R9 release clears ready");
    chk(por_ok, 1'b0, "R9 release clears status");

    // R5: retry without fresh pulse ignored
    go_idle();
    reset_pulse(T_RST);
    open_window();
    send_key(8'hD2, 1'b0);
    chk(por_ok, 1'b0, "R5 wrong key");
    prg_rst = 1'b1; tick();
    open_window();
    send_key(8'hD3, 1'b0);
    chk(por_ok, 1'b0, "R5 retry needs new pulse");
    reset_pulse(T_RST);
    open_window();
    send_key(8'hD3, 1'b1);
    chk(por_ok, 1'b1, "R5 retry after new pulse");

    // R10: long high test clock counts once
    post_clocks(POSTN - 2);
    tck_pulse(1'b0, 3);
    chk(host_mode, 1'b0, "R10 long high counts once");
    tck_pulse(1'b0, 1);
    chk(host_mode, 1'b1, "R10 host after 24 edges");

    // R9: release from host mode, no re-entry
    main_rst_n = 1'b1;
    tick();
    chk(host_mode, 1'b0, "R9 release clears host");
    main_rst_n = 1'b0;
    tick(); tick();
    chk(host_mode, 1'b0, "R9 stays in user mode");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule